// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block watches the stream of finished light-sensor conversion results and decides when to raise an alarm. Each result that arrives with its valid strobe is reduced to its upper byte. That byte is compared against a programmable upper and lower threshold. A result is outside the window when its upper byte is strictly greater than the upper threshold or strictly less than the lower threshold.

A single outside result does not raise the alarm. A run counter must first see a programmed number of consecutive outside results. Any valid in-window result restarts the run. This filtering keeps short events such as a photographic flash from firing the interrupt. Once the alarm fires it stays latched until software pulses a clear.

The output is a drive-low enable for an open-drain, active-low interrupt line. A value of 1 pulls the line low, and 0 releases it.

Top module: `lux_win_irq`

## Requirements
- R1: While reset is high and in the first cycle after it, the drive-low enable is 0 and the run count is zero.
- R2: A valid result is outside the window when its upper byte (bits 15:8) is greater than the upper threshold or less than the lower threshold. A byte equal to either threshold is inside.
- R3: Results and thresholds are evaluated only in cycles where the valid strobe is 1. Other cycles neither advance nor restart the run.
- R4: The persistence select encodes the required run length: 0 means 1, 1 means 4, 2 means 8 and 3 means 16 consecutive outside results.
- R5: A valid in-window result resets the run count to zero, so the required run must start again from the next outside result.
- R6: Once set, the drive-low enable stays at 1 through any further results until a clear strobe arrives.
- R7: A clear strobe releases the interrupt and zeroes the run count in the following cycle. A valid result presented in the same cycle as a clear is discarded.
- R8: The drive-low enable rises one clock after the valid edge that completes the required run.
- R9: The low byte of the result (bits 7:0) has no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_i | input | 16 | Conversion result |
| res_vld_i | input | 1 | Result-valid strobe |
| thr_hi_i | input | 8 | Upper threshold |
| thr_lo_i | input | 8 | Lower threshold |
| persist_sel_i | input | 2 | Run-length select (R4 encoding) |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| irq_drv_low_o | output | 1 | 1 = pull interrupt line low |

## Verification
The bench aims at results whose upper byte exactly equals a threshold. A comparator that uses the wrong inequality would fire on these. It also feeds runs that fall one short of the required length and are then broken by an in-window result. A counter that only paused, instead of restarting, would then fire early. Out-of-window values presented with the valid strobe low must not count, or the alarm would fire ahead of the run. A clear that coincides with an outside result must win, or the interrupt would reappear at once. A long pseudo-random phase compares the output against a behavioural model on every clock.

// File: rtl/lux_win_pkg.sv
package lux_win_pkg;

    localparam int RES_W   = 16;
    localparam int THR_W   = 8;
    localparam int RUN_MAX = 16;
    localparam int CNT_W   = $clog2(RUN_MAX + 1);

    typedef enum logic [1:0] {
        PERS_1  = 2'd0,
        PERS_4  = 2'd1,
        PERS_8  = 2'd2,
        PERS_16 = 2'd3
    } pers_sel_e;

    typedef struct packed {
        logic above;
        logic below;
    } win_flags_t;

    function automatic logic [CNT_W:0] pers_len(pers_sel_e s);
        case (s)
            PERS_1:  pers_len = (CNT_W+1)'(1);
            PERS_4:  pers_len = (CNT_W+1)'(4);
            PERS_8:  pers_len = (CNT_W+1)'(8);
            default: pers_len = (CNT_W+1)'(RUN_MAX);
        endcase
    endfunction

    function automatic logic is_outside(win_flags_t f);
        is_outside = f.above | f.below;
    endfunction

endpackage

// File: rtl/lux_win_cmp.sv
module lux_win_cmp
    import lux_win_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int TW = THR_W
) (
    input  logic [RW-1:0] res,
    input  logic [TW-1:0] thr_hi,
    input  logic [TW-1:0] thr_lo,
    output win_flags_t    flags
);
    logic [TW-1:0] top_byte;

    always_comb begin
        top_byte    = res[RW-1 -: TW];
        flags.above = (top_byte > thr_hi);
        flags.below = (top_byte < thr_lo);
    end
endmodule

// File: rtl/lux_win_persist.sv
module lux_win_persist
    import lux_win_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      vld,
    input  logic      outside,
    input  pers_sel_e sel,
    output logic      run_done
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
        run_done = vld && outside && !clr && (cnt_inc >= pers_len(sel));
        cnt_d    = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (vld) begin
            if (!outside)
                cnt_d = '0;
            else if (cnt_q != CNT_W'(RUN_MAX))
                cnt_d = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R5
    inwin_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !outside) |=> (cnt_q == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!vld && !clr) |=> $stable(cnt_q));
    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(RUN_MAX));
endmodule

// File: rtl/lux_win_latch.sv
module lux_win_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      irq <= 1'b0;
        else if (clr) irq <= 1'b0;
        else if (set) irq <= 1'b1;
    end

    // R6
    hold_until_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);
    // R7
    clr_release_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq);
endmodule

// File: rtl/lux_win_irq.sv
module lux_win_irq
    import lux_win_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int TW = THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] res_i,
    input  logic          res_vld_i,
    input  logic [TW-1:0] thr_hi_i,
    input  logic [TW-1:0] thr_lo_i,
    input  logic [1:0]    persist_sel_i,
    input  logic          irq_clr_i,
    output logic          irq_drv_low_o
);
    win_flags_t flags;
    logic       outside;
    logic       run_done;

    lux_win_cmp #(.RW(RW), .TW(TW)) cmp_i (
        .res    (res_i),
        .thr_hi (thr_hi_i),
        .thr_lo (thr_lo_i),
        .flags  (flags)
    );

    assign outside = is_outside(flags);

    lux_win_persist pers_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (irq_clr_i),
        .vld      (res_vld_i),
        .outside  (outside),
        .sel      (pers_sel_e'(persist_sel_i)),
        .run_done (run_done)
    );

    lux_win_latch latch_i (
        .clk (clk),
        .rst (rst),
        .set (run_done),
        .clr (irq_clr_i),
        .irq (irq_drv_low_o)
    );

    // R8
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_drv_low_o) |-> $past(res_vld_i && outside && !irq_clr_i));
    // R2
    single_run_chk: assert property (@(posedge clk) disable iff (rst)
        (persist_sel_i == 2'd0 && res_vld_i && outside && !irq_clr_i) |=> irq_drv_low_o);
endmodule

// File: tb/lux_win_irq_tb.sv
module lux_win_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] res = '0;
    logic        vld = 1'b0;
    logic [7:0]  hi  = 8'h80;
    logic [7:0]  lo  = 8'h20;
    logic [1:0]  sel = 2'd0;
    logic        clr = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_irq = 0;

    always #2 clk = ~clk;

    lux_win_irq dut_i (
        .clk(clk), .rst(rst), .res_i(res), .res_vld_i(vld),
        .thr_hi_i(hi), .thr_lo_i(lo), .persist_sel_i(sel),
        .irq_clr_i(clr), .irq_drv_low_o(irq)
    );

    function automatic int need(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic check(string tag, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_drv_low actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One clock with given inputs; model updated and output compared after edge
    task automatic step(string tag, logic [15:0] r, bit v, bit c);
        int ub;
        @(negedge clk);
        res = r; vld = v; clr = c;
        @(posedge clk);
        ub = r[15:8];
        if (c) begin
            m_cnt = 0; m_irq = 0;
        end else if (v) begin
            if (ub > hi || ub < lo) begin
                if (m_cnt < 16) m_cnt++;
                if (m_cnt >= need(sel)) m_irq = 1;
            end else m_cnt = 0;
        end
        #1;
        check(tag, irq, m_irq);
    endtask

    task automatic outs(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 16'hF000, 1, 0);
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", irq, 0);
        @(negedge clk); rst = 0;
        step("R1 after reset", 16'h5000, 0, 0);

        // R4 sel=0: one outside result fires; R8 one clock after
        sel = 2'd0;
        step("R4/R8 single", 16'h9000, 1, 0);
        step("R7 clear", 16'h0000, 0, 1);
        // R2 equality is inside
        step("R2 equal hi", 16'h8000, 1, 0);
        step("R2 equal lo", 16'h2000, 1, 0);
        step("R2 below lo", 16'h1FFF, 1, 0);
        step("R7 clear", 16'h0000, 0, 1);
        // R9 low byte ignored
        step("R9 low byte", 16'h80FF, 1, 0);
        step("R9 low byte lo", 16'h2000, 1, 0);
        // R7 clear beats same-cycle valid
        step("R7 clr+vld", 16'hFF00, 1, 1);
        step("R7 after clr+vld", 16'h5000, 0, 0);

        // R5 sel=4: 3 out, 1 in, 3 out -> no irq
        sel = 2'd1;
        outs("R5 run a", 3);
        step("R5 break", 16'h5000, 1, 0);
        outs("R5 run b", 3);
        // R3 invalid cycles neither count nor restart
        step("R3 invalid out", 16'hFF00, 0, 0);
        step("R3 invalid in", 16'h5000, 0, 0);
        outs("R4 fourth", 1);
        // R6 held through in-window results
        step("R6 hold", 16'h5000, 1, 0);
        step("R6 hold", 16'h5000, 1, 0);
        step("R7 clear", 16'h0000, 0, 1);

        // R7 clear zeroes count, sel=8
        sel = 2'd2;
        outs("R7 pre", 5);
        step("R7 mid clear", 16'h0000, 0, 1);
        outs("R7 post", 7);
        outs("R4 eighth", 1);
        step("R7 clear", 16'h0000, 0, 1);

        // R4 sel=16
        sel = 2'd3;
        outs("R4 fifteen", 15);
        outs("R4 sixteenth", 1);
        step("R7 clear", 16'h0000, 0, 1);

        // mixed pseudo-random phase against model
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (k % 200 == 0) begin
                sel = rv[1:0];
                hi  = 8'h60 + 8'(rv[7:4]);
                lo  = 8'h30 + 8'(rv[11:8]);
            end
            step("R2/R3/R5 random", rv[31:16], rv[12] | rv[13], (rv[23:18] == 6'd0));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule